// File: doc/BRIEF.md
# Checksummed Command Frame Receiver

The receiver gathers a fixed-length frame of eight command bytes, presented one per cycle on a byte-valid strobe, and checks the frame when the latch input is pulsed. A frame is good only when the wrapping 8-bit sum of all its bytes is zero. The last byte is a checksum chosen by the sender so that this sum is zero. A good frame loads its decoded fields into shadow registers in a single update. A bad or short frame leaves every shadow register unchanged, drops the checksum-ok flag and raises a stepping-inhibit output, so the motion stage stops rather than running on corrupted settings.

There are two kinds of frame. A standard frame has 1110 in bits 7..4 of its first byte. It carries the open-drain expansion bit in bit 0 of byte 0 and two channel control words in bytes 1 and 2. Any other first byte marks an initialization frame, whose seventh byte carries two 4-bit reference levels.

Top module: `cmd_frame_rx`

## Requirements
- R1: After reset, csum_ok_o=0, step_inhibit_o=1, ref_lo_o=0, ref_hi_o=0, chan_a_o=0, chan_b_o=0 and exp_od_o=1.
- R2: On the clock edge where latch_i is high, the outputs update as follows when exactly eight bytes have been collected and their modulo-256 sum is 0x00: csum_ok_o becomes 1 and step_inhibit_o becomes 0.
- R3: A latch after eight bytes whose sum is not zero sets csum_ok_o=0 and step_inhibit_o=1, and leaves all decoded outputs unchanged.
- R4: A latch after fewer than eight bytes is treated as a checksum failure, with the same outputs as in R3.
- R5: Bytes that arrive after the eighth byte of a frame are ignored and take no part in the sum.
- R6: A passing frame whose byte 0 bits 7..4 are not 1110 is an initialization frame. Its byte 6 bits 3..0 load ref_lo_o and bits 7..4 load ref_hi_o. exp_od_o, chan_a_o and chan_b_o do not change.
- R7: A passing frame whose byte 0 bits 7..4 are 1110 is a standard frame. Its byte 0 bit 0 loads exp_od_o (0 means sink low, 1 means release). Byte 1 loads chan_a_o and byte 2 loads chan_b_o. ref_lo_o and ref_hi_o do not change.
- R8: csum_ok_o and step_inhibit_o change only on a latch edge, and keep their value until the next latch.
- R9: frame_start_i discards all bytes collected so far. It has priority over byte_valid_i and latch_i in the same cycle.
- R10: Every latch empties the collection, so a second latch with no new bytes fails as in R4. A byte strobed in the same cycle as a latch is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Discard collected bytes, begin a new frame |
| byte_valid_i | input | 1 | byte_i holds a frame byte this cycle |
| byte_i | input | 8 | Frame byte |
| latch_i | input | 1 | Evaluate the collected frame |
| ref_lo_o | output | 4 | First reference level |
| ref_hi_o | output | 4 | Second reference level |
| exp_od_o | output | 1 | Open-drain expansion control: 0 sink, 1 release |
| chan_a_o | output | 8 | Channel A control word |
| chan_b_o | output | 8 | Channel B control word |
| csum_ok_o | output | 1 | Result of the last evaluated frame |
| step_inhibit_o | output | 1 | High while stepping is blocked |

## Verification
A wrong byte count or running sum shows at the ports on the first latch after the fault. A good frame then reads as failed, or a short or corrupt frame reads as passed. Both csum_ok_o and step_inhibit_o move on that very edge. A buffer slot written at the wrong index surfaces only when a passing frame of the type that decodes that slot is latched, so frames of both types with varied field values are mixed. Extra bytes, restarted frames and repeated latches are included to expose counter saturation and clearing faults within one frame.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;
  localparam int unsigned FRAME_LEN_DEF = 8;
  localparam logic [3:0]  STD_TAG       = 4'hE;
  typedef logic [7:0] cmd_byte_t;
endpackage

// File: rtl/cmd_frame_acc.sv
module cmd_frame_acc
  import cmd_frame_pkg::*;
#(
  parameter int unsigned FRAME_LEN = FRAME_LEN_DEF,
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      valid_i,
  input  logic                      latch_i,
  input  cmd_byte_t                 data_i,
  output cmd_byte_t [FRAME_LEN-1:0] frame_o,
  output logic [CNT_W-1:0]          cnt_o,
  output cmd_byte_t                 sum_o
);
  logic [CNT_W-1:0] cnt_q;
  cmd_byte_t        sum_q;
  logic             take;

  assign take = valid_i && !start_i && !latch_i && (cnt_q < CNT_W'(FRAME_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (start_i || latch_i) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      sum_q <= sum_q + data_i;
    end
  end

  for (genvar i = 0; i < FRAME_LEN; i++) begin : g_slot
    cmd_byte_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               slot_q <= '0;
      else if (take && cnt_q == CNT_W'(i))       slot_q <= data_i;
    end
    assign frame_o[i] = slot_q;
  end

  assign cnt_o = cnt_q;
  assign sum_o = sum_q;
endmodule

// File: rtl/cmd_frame_shadow.sv
module cmd_frame_shadow
  import cmd_frame_pkg::*;
#(
  parameter int unsigned FRAME_LEN = FRAME_LEN_DEF,
  localparam int unsigned REF_IDX = FRAME_LEN - 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      latch_i,
  input  logic                      pass_i,
  input  cmd_byte_t [FRAME_LEN-1:0] frame_i,
  output logic [3:0]                ref_lo_o,
  output logic [3:0]                ref_hi_o,
  output logic                      exp_od_o,
  output cmd_byte_t                 chan_a_o,
  output cmd_byte_t                 chan_b_o,
  output logic                      csum_ok_o,
  output logic                      step_inhibit_o
);
  logic is_std;
  assign is_std = (frame_i[0][7:4] == STD_TAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_lo_o       <= '0;
      ref_hi_o       <= '0;
      exp_od_o       <= 1'b1;
      chan_a_o       <= '0;
      chan_b_o       <= '0;
      csum_ok_o      <= 1'b0;
      step_inhibit_o <= 1'b1;
    end else if (latch_i) begin
      csum_ok_o      <= pass_i;
      step_inhibit_o <= !pass_i;
      if (pass_i) begin
        if (is_std) begin
          exp_od_o <= frame_i[0][0];
          chan_a_o <= frame_i[1];
          chan_b_o <= frame_i[2];
        end else begin
          ref_lo_o <= frame_i[REF_IDX][3:0];
          ref_hi_o <= frame_i[REF_IDX][7:4];
        end
      end
    end
  end
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cmd_frame_pkg::*;
#(
  parameter int unsigned FRAME_LEN = FRAME_LEN_DEF,
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_start_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       latch_i,
  output logic [3:0] ref_lo_o,
  output logic [3:0] ref_hi_o,
  output logic       exp_od_o,
  output logic [7:0] chan_a_o,
  output logic [7:0] chan_b_o,
  output logic       csum_ok_o,
  output logic       step_inhibit_o
);
  cmd_byte_t [FRAME_LEN-1:0] frame;
  logic [CNT_W-1:0]          cnt;
  cmd_byte_t                 sum;
  logic                      do_latch;
  logic                      pass;

  assign do_latch = latch_i && !frame_start_i;
  assign pass     = (cnt == CNT_W'(FRAME_LEN)) && (sum == '0);

  cmd_frame_acc #(.FRAME_LEN(FRAME_LEN)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (frame_start_i),
    .valid_i (byte_valid_i),
    .latch_i (do_latch),
    .data_i  (byte_i),
    .frame_o (frame),
    .cnt_o   (cnt),
    .sum_o   (sum)
  );

  cmd_frame_shadow #(.FRAME_LEN(FRAME_LEN)) u_shadow (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .latch_i        (do_latch),
    .pass_i         (pass),
    .frame_i        (frame),
    .ref_lo_o       (ref_lo_o),
    .ref_hi_o       (ref_hi_o),
    .exp_od_o       (exp_od_o),
    .chan_a_o       (chan_a_o),
    .chan_b_o       (chan_b_o),
    .csum_ok_o      (csum_ok_o),
    .step_inhibit_o (step_inhibit_o)
  );
endmodule

// File: rtl/cmd_frame_rx_chk.sv
module cmd_frame_rx_chk #(
  parameter int unsigned FRAME_LEN = 8,
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             latch_i,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       sum,
  input logic [3:0]       ref_lo_o,
  input logic [3:0]       ref_hi_o,
  input logic             exp_od_o,
  input logic [7:0]       chan_a_o,
  input logic [7:0]       chan_b_o,
  input logic             csum_ok_o,
  input logic             step_inhibit_o
);
  logic lat;
  assign lat = latch_i && !frame_start_i;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(FRAME_LEN));

  p_start_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> cnt == '0);

  p_latch_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat |=> cnt == '0);

  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat && cnt == CNT_W'(FRAME_LEN) && sum == 8'h00 |=> csum_ok_o && !step_inhibit_o);

  p_bad_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat && sum != 8'h00 |=> !csum_ok_o && step_inhibit_o && $stable(ref_lo_o)
      && $stable(ref_hi_o) && $stable(exp_od_o) && $stable(chan_a_o) && $stable(chan_b_o));

  p_short_fail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat && cnt != CNT_W'(FRAME_LEN) |=> !csum_ok_o && step_inhibit_o && $stable(ref_lo_o)
      && $stable(chan_a_o));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat |=> $stable(csum_ok_o) && $stable(step_inhibit_o));
endmodule

bind cmd_frame_rx cmd_frame_rx_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .frame_start_i  (frame_start_i),
  .latch_i        (latch_i),
  .cnt            (cnt),
  .sum            (sum),
  .ref_lo_o       (ref_lo_o),
  .ref_hi_o       (ref_hi_o),
  .exp_od_o       (exp_od_o),
  .chan_a_o       (chan_a_o),
  .chan_b_o       (chan_b_o),
  .csum_ok_o      (csum_ok_o),
  .step_inhibit_o (step_inhibit_o)
);

// File: tb/cmd_frame_rx_tb_top.sv
module cmd_frame_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, valid = 1'b0, latch = 1'b0;
  logic [7:0] data = 8'h00;
  logic [3:0] ref_lo, ref_hi;
  logic       exp_od, ok, inh;
  logic [7:0] ch_a, ch_b;

  int checks = 0, fails = 0;

  // bench model
  logic [7:0] m_f [8];
  int         m_n = 0;
  logic [3:0] e_lo = 0, e_hi = 0;
  logic       e_exp = 1, e_ok = 0;
  logic [7:0] e_a = 0, e_b = 0;

  always #4 clk = ~clk;

  cmd_frame_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(start), .byte_valid_i(valid),
    .byte_i(data), .latch_i(latch), .ref_lo_o(ref_lo), .ref_hi_o(ref_hi),
    .exp_od_o(exp_od), .chan_a_o(ch_a), .chan_b_o(ch_b), .csum_ok_o(ok),
    .step_inhibit_o(inh)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "csum_ok", int'(ok), int'(e_ok));
    chk(req, "inhibit", int'(inh), int'(!e_ok));
    chk(req, "refs", int'({ref_hi, ref_lo}), int'({e_hi, e_lo}));
    chk(req, "exp_od", int'(exp_od), int'(e_exp));
    chk(req, "chans", int'({ch_a, ch_b}), int'({e_a, e_b}));
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    m_n = 0;
  endtask

  task automatic do_byte(input logic [7:0] b);
    @(negedge clk); valid = 1'b1; data = b;
    @(negedge clk); valid = 1'b0;
    if (m_n < 8) begin m_f[m_n] = b; m_n++; end
    repeat ($urandom % 2) @(negedge clk);
  endtask

  function automatic logic frame_pass();
    logic [7:0] s = 8'h00;
    if (m_n != 8) return 1'b0;
    for (int i = 0; i < 8; i++) s = s + m_f[i];
    return s == 8'h00;
  endfunction

  task automatic do_latch(input string req);
    @(negedge clk); latch = 1'b1;
    @(negedge clk); latch = 1'b0;
    e_ok = frame_pass();
    if (e_ok) begin
      if (m_f[0][7:4] == 4'hE) begin
        e_exp = m_f[0][0]; e_a = m_f[1]; e_b = m_f[2];
      end else begin
        e_lo = m_f[6][3:0]; e_hi = m_f[6][7:4];
      end
    end
    m_n = 0;
    chk_all(req);
  endtask

  function automatic logic [7:0] mk_b0(input logic std);
    logic [7:0] b = 8'($urandom);
    if (std) b[7:4] = 4'hE;
    else if (b[7:4] == 4'hE) b[7:4] = 4'h3;
    return b;
  endfunction

  // build 8 bytes with valid checksum; mode 1 corrupts it
  task automatic send_frame(input logic std, input int mode, input int nbytes);
    logic [7:0] f [8];
    logic [7:0] s = 8'h00;
    f[0] = mk_b0(std);
    for (int i = 1; i < 7; i++) f[i] = 8'($urandom);
    for (int i = 0; i < 7; i++) s = s + f[i];
    f[7] = 8'h00 - s;
    if (mode == 1) f[7] = f[7] + 8'(1 + $urandom % 255);
    for (int i = 0; i < nbytes; i++) do_byte(f[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R6 init frame, directed
    do_start();
    begin
      logic [7:0] fr [8] = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h00};
      fr[7] = 8'h00 - 8'h01 - 8'hA5;
      for (int i = 0; i < 8; i++) do_byte(fr[i]);
    end
    do_latch("R6");
    chk("R6", "ref_lo", int'(ref_lo), 5);
    chk("R6", "ref_hi", int'(ref_hi), 10);

    // R7 standard frame, directed, exp sink
    do_start();
    begin
      logic [7:0] fr [8] = '{8'hE0, 8'h3C, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h77, 8'h00};
      fr[7] = 8'h00 - 8'hE0 - 8'h3C - 8'hC3 - 8'h77;
      for (int i = 0; i < 8; i++) do_byte(fr[i]);
    end
    do_latch("R7");
    chk("R7", "exp_od sink", int'(exp_od), 0);
    chk("R2", "pass", int'(ok), 1);

    // R8 hold with no latch
    repeat (20) @(negedge clk);
    chk_all("R8");

    // R3 bad sum
    do_start(); send_frame(1'b0, 1, 8); do_latch("R3");
    // R4 short
    do_start(); send_frame(1'b1, 0, 7); do_latch("R4");
    // R5 extra bytes ignored
    do_start(); send_frame(1'b1, 0, 8); do_byte(8'h5A); do_byte(8'h01); do_latch("R5");
    chk("R5", "pass with extra", int'(ok), 1);
    // R10 second latch fails
    do_latch("R10");
    chk("R10", "repeat latch", int'(ok), 0);
    // R9 restart discards partial bytes
    send_frame(1'b0, 0, 3); do_start(); send_frame(1'b0, 0, 8); do_latch("R9");
    chk("R9", "pass after restart", int'(ok), 1);
    // R10 byte during latch is dropped: 7 bytes, then 8th with latch -> short
    do_start(); send_frame(1'b1, 0, 7);
    @(negedge clk); valid = 1'b1; data = 8'hFF; latch = 1'b1;
    @(negedge clk); valid = 1'b0; latch = 1'b0;
    e_ok = 1'b0; m_n = 0;
    chk_all("R10");

    // random mix
    for (int k = 0; k < 300; k++) begin
      int mode = $urandom % 4;
      logic std = 1'($urandom);
      do_start();
      case (mode)
        0: send_frame(std, 0, 8);
        1: send_frame(std, 1, 8);
        2: send_frame(std, 0, 1 + $urandom % 7);
        default: begin send_frame(std, 0, 8); do_byte(8'($urandom)); end
      endcase
      do_latch(mode == 1 ? "R3" : mode == 2 ? "R4" : std ? "R7" : "R6");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule